// File: doc/BRIEF.md
# Map-Stage Sequencer with Refresh Handshake

This block runs the address-map stage of a cached memory pipeline. A request is offered with `req_valid` and a set of kind flags (read, write, refresh, privileged). When the stage is free it takes the request, turns the kind flags into a two-bit function code, and then walks a step counter through a small control ROM. Each ROM entry drives the DRAM-style row and column strobes, the map, reference and dirty write enables, a start-memory request, a memory-refresh marker, a pipe request and the stage's own free flag.

The request side follows a valid/ready rule. `req_ready` is the registered free flag, and a request is taken only in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold its request; nothing is queued. A map-wait condition freezes the stage. It is raised when the stage is idle with nothing offered, or when the current ROM entry asks to start memory while memory reports busy. The block also numbers accepted ordinary requests with a small serial counter that skips its two lowest values on wrap. It keeps a pending-refresh flag, which an external tick sets and which clears once the refresh has been handed out.

Top module: `map_stage_seq`

## Requirements
- R1: On a taken request the function code (`fn_state[4:3]`) becomes octal 3 with bit 1 cleared by read or refresh and bit 0 cleared by write or refresh. This gives read 01, write 10, read+write 00, refresh 00 and none 11. The step (`fn_state[2:0]`) becomes 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is the ROM free bit of the current state. A request offered while not ready changes nothing.
- R3: In a cycle with no taken request, the state holds while `map_wait` is high. Otherwise the step adds 1 modulo 8 and the function code is kept.
- R4: `map_wait` = (not `req_valid` and `req_ready`) or (`start_mem` and `mem_busy`).
- R5: `serial` resets to 2 and advances by one on each taken request that is neither privileged nor a refresh. After 15 (octal 17) it goes to 2.
- R6: The control outputs come from flops and equal the ROM entry of the current state. Code 01 (read): step 0 = row_strobe+start_mem, step 1 = col_strobe+pipe_req, later steps = free. Code 10 (write): step 0 = row_strobe+start_mem, step 1 = col_strobe+map_we+dirty_we, step 2 = ref_we+pipe_req, later = free. Code 00 (refresh): step 0 = mem_rfsh+row_strobe, later = free. Code 11: step 0 = pipe_req, later = free.
- R7: `map_rfsh` = pending-refresh flag and `req_ready`. The flag is set by `rfsh_tick` and cleared in the cycle after `map_rfsh` is high, unless a tick arrives in that same cycle.
- R8: While `map_load` is high, `map_we` and `dirty_we` are low whatever the ROM entry.
- R9: After reset the state is code 11, step 1. The stage is ready, only the free bit is set among the ROM outputs, `serial` is 2 and no refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Stage free, request may be taken |
| req_read | input | 1 | Request kind: read |
| req_write | input | 1 | Request kind: write |
| req_refresh | input | 1 | Request kind: refresh |
| req_priv | input | 1 | Privileged request, not numbered |
| mem_busy | input | 1 | Memory cannot start yet |
| rfsh_tick | input | 1 | Sets the pending-refresh flag |
| map_load | input | 1 | Map-load command, blocks map and dirty writes |
| fn_state | output | 5 | Function code (4:3) and step (2:0) |
| serial | output | 4 | Request serial number |
| map_wait | output | 1 | Stage frozen this cycle |
| map_rfsh | output | 1 | Refresh handed to the map |
| row_strobe | output | 1 | Row strobe |
| col_strobe | output | 1 | Column strobe |
| map_we | output | 1 | Map write enable |
| ref_we | output | 1 | Reference write enable |
| dirty_we | output | 1 | Dirty write enable |
| start_mem | output | 1 | Start-memory request |
| mem_rfsh | output | 1 | Memory refresh cycle marker |
| pipe_req | output | 1 | Pipe request |

## Verification
Each request kind is driven: read, write, read with write, refresh, and none. Each one produces a different code and a different ROM walk, so a wrong mask term or a swapped bit shows up as a wrong strobe sequence. Holding `mem_busy` while a start-memory step is live separates the freeze from normal stepping. A request offered mid-walk checks the ready rule. Privileged and refresh requests are mixed with ordinary ones to show the serial counter skips them, and a long run of ordinary requests drives it through 13, 14, 15 and on to 2. Refresh ticks, and a map-load pulse during the write step that enables both write strobes, cover the refresh handshake and the write blocking.

// File: rtl/map_seq_pkg.sv
`timescale 1ns/1ps
package map_seq_pkg;

  typedef struct packed {
    logic mem_rfsh;
    logic row_strobe;
    logic col_strobe;
    logic map_we;
    logic ref_we;
    logic dirty_we;
    logic start_mem;
    logic free;
    logic pipe_req;
  } map_ctl_t;

  localparam logic [1:0] CODE_RFSH  = 2'b00;
  localparam logic [1:0] CODE_READ  = 2'b01;
  localparam logic [1:0] CODE_WRITE = 2'b10;
  localparam logic [1:0] CODE_PLAIN = 2'b11;

  function automatic map_ctl_t rom_lookup(input logic [1:0] code, input int unsigned step);
    map_ctl_t r;
    r = '0;
    unique case (code)
      CODE_READ: begin
        if (step == 0) begin r.row_strobe = 1'b1; r.start_mem = 1'b1; end
        else if (step == 1) begin r.col_strobe = 1'b1; r.pipe_req = 1'b1; end
        else r.free = 1'b1;
      end
      CODE_WRITE: begin
        if (step == 0) begin r.row_strobe = 1'b1; r.start_mem = 1'b1; end
        else if (step == 1) begin r.col_strobe = 1'b1; r.map_we = 1'b1; r.dirty_we = 1'b1; end
        else if (step == 2) begin r.ref_we = 1'b1; r.pipe_req = 1'b1; end
        else r.free = 1'b1;
      end
      CODE_RFSH: begin
        if (step == 0) begin r.mem_rfsh = 1'b1; r.row_strobe = 1'b1; end
        else r.free = 1'b1;
      end
      default: begin
        if (step == 0) r.pipe_req = 1'b1;
        else r.free = 1'b1;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/map_fn_encode.sv
`timescale 1ns/1ps
module map_fn_encode (
  input  logic       is_read,
  input  logic       is_write,
  input  logic       is_refresh,
  output logic [1:0] code
);
  logic [1:0] mask;
  always_comb begin
    mask = {is_read, 1'b0} | {is_refresh, is_refresh} | {1'b0, is_write};
    code = 2'b11 & ~mask;
  end
endmodule

// File: rtl/map_step_seq.sv
`timescale 1ns/1ps
module map_step_seq
  import map_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [1:0]        new_code,
  input  logic              hold,
  output logic [STEP_W+1:0] state,
  output map_ctl_t          ctl
);
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

  logic [1:0]        code_q, code_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    code_d = code_q;
    step_d = step_q;
    if (take) begin
      code_d = new_code;
      step_d = '0;
    end else if (!hold) begin
      step_d = step_q + STEP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_PLAIN;
      step_q <= STEP_ONE;
      ctl    <= rom_lookup(CODE_PLAIN, 1);
    end else begin
      code_q <= code_d;
      step_q <= step_d;
      ctl    <= rom_lookup(code_d, int'(step_d));
    end
  end

  assign state = {code_q, step_q};
endmodule

// File: rtl/map_serial_ctr.sv
`timescale 1ns/1ps
module map_serial_ctr #(
  parameter int SER_W   = 4,
  parameter int WRAP_TO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [SER_W-1:0] count
);
  localparam logic [SER_W-1:0] TOP  = {SER_W{1'b1}};
  localparam logic [SER_W-1:0] BASE = SER_W'(WRAP_TO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= BASE;
    else if (bump) begin
      if (count == TOP)  count <= BASE;
      else               count <= count + SER_W'(1);
    end
  end
endmodule

// File: rtl/map_rfsh_flag.sv
`timescale 1ns/1ps
module map_rfsh_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic taken,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending & ~taken) | tick;
  end
endmodule

// File: rtl/map_stage_seq.sv
`timescale 1ns/1ps
module map_stage_seq
  import map_seq_pkg::*;
#(
  parameter int STEP_W  = 3,
  parameter int SER_W   = 4,
  parameter int WRAP_TO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_write,
  input  logic              req_refresh,
  input  logic              req_priv,
  input  logic              mem_busy,
  input  logic              rfsh_tick,
  input  logic              map_load,
  output logic [STEP_W+1:0] fn_state,
  output logic [SER_W-1:0]  serial,
  output logic              map_wait,
  output logic              map_rfsh,
  output logic              row_strobe,
  output logic              col_strobe,
  output logic              map_we,
  output logic              ref_we,
  output logic              dirty_we,
  output logic              start_mem,
  output logic              mem_rfsh,
  output logic              pipe_req
);
  map_ctl_t   ctl;
  logic [1:0] code;
  logic       take;
  logic       want_rfsh;

  assign req_ready = ctl.free;
  assign take      = req_valid & ctl.free;
  assign map_wait  = (~req_valid & ctl.free) | (ctl.start_mem & mem_busy);
  assign map_rfsh  = want_rfsh & ctl.free;

  map_fn_encode u_enc (
    .is_read    (req_read),
    .is_write   (req_write),
    .is_refresh (req_refresh),
    .code       (code)
  );

  map_step_seq #(.STEP_W(STEP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .new_code (code),
    .hold     (map_wait),
    .state    (fn_state),
    .ctl      (ctl)
  );

  map_serial_ctr #(.SER_W(SER_W), .WRAP_TO(WRAP_TO)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (take & ~req_priv & ~req_refresh),
    .count (serial)
  );

  map_rfsh_flag u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (rfsh_tick),
    .taken   (map_rfsh),
    .pending (want_rfsh)
  );

  assign row_strobe = ctl.row_strobe;
  assign col_strobe = ctl.col_strobe;
  assign map_we     = ctl.map_we & ~map_load;
  assign ref_we     = ctl.ref_we;
  assign dirty_we   = ctl.dirty_we & ~map_load;
  assign start_mem  = ctl.start_mem;
  assign mem_rfsh   = ctl.mem_rfsh;
  assign pipe_req   = ctl.pipe_req;
endmodule

// File: rtl/map_seq_chk.sv
`timescale 1ns/1ps
module map_seq_chk #(
  parameter int STEP_W = 3,
  parameter int SER_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_refresh,
  input logic              req_priv,
  input logic              mem_busy,
  input logic              rfsh_tick,
  input logic              map_load,
  input logic [STEP_W+1:0] fn_state,
  input logic [SER_W-1:0]  serial,
  input logic              map_wait,
  input logic              map_rfsh,
  input logic              map_we,
  input logic              dirty_we,
  input logic              start_mem
);
  logic took;
  assign took = req_valid && req_ready;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_wait |=> $stable(fn_state));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_wait && !took) |=>
      (fn_state[STEP_W-1:0] == STEP_W'($past(fn_state[STEP_W-1:0]) + 1'b1))
      && $stable(fn_state[STEP_W+1:STEP_W]));

  p_take_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (fn_state[STEP_W-1:0] == '0));

  p_busy_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_mem && mem_busy) |-> map_wait);

  p_serial_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !req_priv && !req_refresh && serial == {SER_W{1'b1}}) |=> (serial == SER_W'(2)));

  p_serial_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(took && !req_priv && !req_refresh) |=> $stable(serial));

  p_rfsh_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_rfsh && !rfsh_tick) |=> !map_rfsh);

  p_load_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_load |-> (!map_we && !dirty_we));
endmodule

bind map_stage_seq map_seq_chk #(.STEP_W(STEP_W), .SER_W(SER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_refresh (req_refresh),
  .req_priv    (req_priv),
  .mem_busy    (mem_busy),
  .rfsh_tick   (rfsh_tick),
  .map_load    (map_load),
  .fn_state    (fn_state),
  .serial      (serial),
  .map_wait    (map_wait),
  .map_rfsh    (map_rfsh),
  .map_we      (map_we),
  .dirty_we    (dirty_we),
  .start_mem   (start_mem)
);

// File: tb/sim_map_stage_seq.sv
`timescale 1ns/1ps
module sim_map_stage_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_read = 0, req_write = 0, req_refresh = 0, req_priv = 0;
  logic mem_busy = 0, rfsh_tick = 0, map_load = 0;
  logic req_ready, map_wait, map_rfsh;
  logic row_strobe, col_strobe, map_we, ref_we, dirty_we, start_mem, mem_rfsh, pipe_req;
  logic [4:0] fn_state;
  logic [3:0] serial;

  always #2.5 clk = ~clk;

  map_stage_seq u0 (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] fn;
    logic [3:0] ser;
    logic       load;
    string      tag;
  } exp_t;
  exp_t q[$];
  event sample_ev;

  logic [4:0] m_fn;
  logic [3:0] m_ser;
  logic       m_want;

  // expected ROM word per R6: {mem_rfsh,row,col,map_we,ref_we,dirty_we,start_mem,free,pipe}
  function automatic logic [8:0] exp_rom(input logic [4:0] f);
    logic [2:0] s;
    s = f[2:0];
    case (f[4:3])
      2'b01: return (s == 0) ? 9'b010000100 : (s == 1) ? 9'b001000001 : 9'b000000010;
      2'b10: return (s == 0) ? 9'b010000100 : (s == 1) ? 9'b001101000 :
                    (s == 2) ? 9'b000010001 : 9'b000000010;
      2'b00: return (s == 0) ? 9'b110000000 : 9'b000000010;
      default: return (s == 0) ? 9'b000000001 : 9'b000000010;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: called at a negedge; applies inputs, checks combinational outputs, queues the state expected after the edge
  task automatic drive(input logic v, rd, wr, rf, pr, busy, tick, load, input string tag);
    logic [8:0] r;
    logic ew, er, acc;
    exp_t e;
    req_valid = v; req_read = rd; req_write = wr; req_refresh = rf; req_priv = pr;
    mem_busy = busy; rfsh_tick = tick; map_load = load;
    #1;
    r = exp_rom(m_fn);
    ew = (!v && r[1]) || (r[2] && busy);
    er = m_want && r[1];
    check(map_wait == ew, "R4", {tag, " map_wait"}, map_wait, ew);
    check(req_ready == r[1], "R2", {tag, " ready"}, req_ready, r[1]);
    check(map_rfsh == er, "R7", {tag, " map_rfsh"}, map_rfsh, er);
    acc = v && r[1];
    if (acc) begin
      m_fn = 5'o30 & ~((rd ? 5'o20 : 5'o0) | (rf ? 5'o30 : 5'o0) | (wr ? 5'o10 : 5'o0));
      if (!pr && !rf) m_ser = (m_ser == 4'd15) ? 4'd2 : m_ser + 4'd1;
    end else if (!ew) begin
      m_fn[2:0] = m_fn[2:0] + 3'd1;
    end
    m_want = (m_want && !er) || tick;
    e.fn = m_fn; e.ser = m_ser; e.load = load; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    ->sample_ev;
    @(negedge clk);
  endtask

  // monitor: pops expected items after each edge and compares
  initial forever begin
    exp_t e;
    logic [8:0] r, a;
    @(sample_ev);
    #1;
    if (q.size() == 0) begin
      check(0, "R3", "queue empty", 0, 1);
    end else begin
      e = q.pop_front();
      r = exp_rom(e.fn);
      if (e.load) begin r[5] = 1'b0; r[3] = 1'b0; end
      a = {mem_rfsh, row_strobe, col_strobe, map_we, ref_we, dirty_we, start_mem, req_ready, pipe_req};
      check(fn_state == e.fn, "R1/R3", {e.tag, " fn_state"}, fn_state, e.fn);
      check(serial == e.ser, "R5", {e.tag, " serial"}, serial, e.ser);
      check(a == r, "R6/R8", {e.tag, " ctl"}, a, r);
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic run_out(input string tag);
    for (int i = 0; i < 8; i++) begin
      if (exp_rom(m_fn)[1]) break;
      drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_fn = 5'o31; m_ser = 4'd2; m_want = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(fn_state == 5'o31, "R9", "reset fn_state", fn_state, 5'o31);
    check(serial == 4'd2, "R9", "reset serial", serial, 2);
    check(req_ready && !row_strobe && !start_mem && !pipe_req && !map_rfsh, "R9", "reset outputs", req_ready, 1);

    idle(2, "R3 idle hold");
    // R1 read, with R4 busy freeze on the start-memory step
    drive(1, 1, 0, 0, 0, 0, 0, 0, "R1 read");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R4 busy hold");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R4 busy hold");
    // R2 offer while not ready: ignored
    drive(1, 0, 1, 0, 0, 0, 0, 0, "R2 not ready");
    run_out("R3 read run");
    check(fn_state == 5'o12, "R3", "read end step", fn_state, 5'o12);
    // R1 write with R8 map_load on the write step
    drive(1, 0, 1, 0, 0, 0, 0, 0, "R1 write");
    drive(0, 0, 0, 0, 0, 0, 0, 1, "R8 load");
    run_out("R6 write run");
    drive(1, 0, 1, 0, 0, 0, 0, 0, "R1 write2");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R6 write step1");
    check(map_we && dirty_we && col_strobe, "R6", "write step1 enables", {map_we, dirty_we}, 3);
    run_out("R6 write run");
    drive(1, 1, 1, 0, 0, 0, 0, 0, "R1 read+write");
    run_out("R1 rw run");
    drive(1, 0, 0, 1, 0, 0, 1, 0, "R1 refresh, R7 tick");
    run_out("R7 refresh run");
    idle(2, "R7 rfsh handout");
    drive(1, 0, 0, 0, 1, 0, 0, 0, "R5 privileged");
    run_out("R5 priv run");
    drive(1, 0, 0, 0, 0, 0, 0, 0, "R1 plain");
    run_out("R1 plain run");
    // R5 wrap: walk plain requests until 15, then confirm the next value is 2
    for (int k = 0; k < 16; k++) begin
      if (m_ser == 4'd15) break;
      drive(1, 0, 0, 0, 0, 0, 0, 0, "R5 count");
      run_out("R5 count run");
    end
    check(serial == 4'd15, "R5", "before wrap", serial, 15);
    drive(1, 1, 0, 0, 0, 0, 0, 0, "R5 wrap");
    check(serial == 4'd2, "R5", "after wrap", serial, 2);
    run_out("R5 wrap run");
    idle(2, "R3 final idle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule